// File: doc/BRIEF.md
# Successive-Approximation Conversion Sequencer

This block is the digital controller of a 10-bit successive-approximation analog-to-digital converter. Software drives it through four byte-wide registers: control, configuration, and two result bytes. It writes an enable bit and then a start bit, and picks a conversion clock in the configuration register. The block then tests one result bit per conversion-clock enable, most significant bit first. On each test it presents a trial code to the external DAC and reads the external comparator.

The conversion clock enable comes from one of two sources. The first is a divider of the system clock, with six ratios from 2 to 64. The second is a tick from a slow RC oscillator, which is synchronized into the system domain first. When the last bit is decided, the block writes the result into the two result bytes in a single cycle. The layout is left- or right-justified, as selected. In the same cycle it clears the busy bit and sets a sticky done flag, which also drives the interrupt output. Software can abort a conversion, and a reset aborts one as well. A sleep input halts the divided clock but leaves the RC path running.

Top module: `sar_adc_ctrl`

## Requirements
- R1: Synchronous reset clears every register (control, configuration, both result bytes, the done flag), stops any conversion and forces `dac_code` to 0.
- R2: Register map: address 0 control (bit0 enable, bit1 start/busy, bit2 done flag), address 1 configuration (bit7 format, bits 2:0 clock select, bits 6:3 read 0), address 2 result high byte, address 3 result low byte. Writes to addresses 2 and 3 are ignored.
- R3: Clock-select codes 000, 100, 001, 101, 010 and 110 divide the system clock by 2, 4, 8, 16, 32 and 64. With divide ratio N, busy reads 1 for exactly 10·N cycles after the start write edge and reads 0 from the next cycle on.
- R4: Codes 011 and 111 ignore the divider. Each `rc_tick` pulse decides one bit, a few cycles after the pulse. A conversion completes after the tenth pulse and never without it.
- R5: While busy, `dac_code` equals the bits decided so far with a 1 in the bit under test. It is 10'h200 in the first cycle after start. A bit is kept as 1 when `cmp_in` is 1 at its step.
- R6: With format 0 (left), the high byte holds result bits 9:2, and the low byte holds bits 1:0 in its bits 7:6, with zeros below.
- R7: With format 1 (right), the high byte holds result bits 9:8 in its bits 1:0, with zeros above, and the low byte holds bits 7:0.
- R8: On completion, the result bytes load, busy clears, the done flag sets and `irq` rises, all on the same clock edge.
- R9: A start write is accepted only if the enable bit was already 1 before that write and the write's own enable bit is 1. Otherwise nothing starts.
- R10: Writing control with start=0 or enable=0 during a conversion aborts it. The result bytes and the done flag keep their values.
- R11: The done flag clears only when control is written with bit2=0. Writing bit2=1 has no effect on it. A completion on the same edge as a clearing write leaves the flag set.
- R12: While `sleep_req` is 1, the divided clock makes no steps and the conversion holds where it is. It resumes when `sleep_req` falls. RC-tick steps continue during sleep.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address for write and read |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data of the register at `reg_addr` (combinational) |
| cmp_in | input | 1 | Comparator output: 1 when the input is at or above the trial code |
| rc_tick | input | 1 | Asynchronous pulse from the RC conversion oscillator |
| sleep_req | input | 1 | Halts the divided conversion clock |
| dac_code | output | 10 | Trial code for the DAC, 0 when idle |
| irq | output | 1 | Done flag |

## Verification
With a divide ratio N, the bench counts edges from the start write. It reads busy after edge 10·N−1, where busy must still be 1, and again after edge 10·N, where busy must be 0 and the result bytes and flag must have their final values. It samples half a clock after each edge. The trial code is checked one cycle after the start edge. The RC path has a synchronizer latency of two edges, so the bench leaves several cycles between each tick and the next read. For the clear-versus-completion race, the bench places the clearing write on exactly the 20th edge of a divide-by-2 conversion.

// File: rtl/sar_pkg.sv
`timescale 1ns/1ps
package sar_pkg;
    localparam int RES_W    = 10;
    localparam int BYTE_W   = 8;
    localparam int SEL_W    = 3;
    localparam int CNT_W    = 6;
    localparam int IDX_W    = $clog2(RES_W);
    localparam int PAD_W    = 2 * BYTE_W - RES_W;

    localparam int EN_BIT   = 0;
    localparam int GO_BIT   = 1;
    localparam int FLAG_BIT = 2;
    localparam int FMT_BIT  = 7;

    typedef enum logic [1:0] {
        ADDR_CTRL = 2'd0,
        ADDR_CFG  = 2'd1,
        ADDR_RHI  = 2'd2,
        ADDR_RLO  = 2'd3
    } reg_addr_e;

    typedef struct packed {
        logic             fmt_right;
        logic [SEL_W-1:0] clk_sel;
    } cfg_t;

    typedef struct packed {
        logic [BYTE_W-1:0] hi;
        logic [BYTE_W-1:0] lo;
    } res_pair_t;

    typedef struct packed {
        logic             active;
        logic [IDX_W-1:0] idx;
        logic [RES_W-1:0] bits;
    } sar_state_t;

    // Codes with both low bits set pick the RC oscillator
    function automatic logic is_rc_sel(input logic [SEL_W-1:0] sel);
        return sel[1:0] == 2'b11;
    endfunction

    // Ratio is 2^(2*sel[1:0] + 1 + sel[2]); returns ratio-1
    function automatic logic [CNT_W-1:0] div_terminal(input logic [SEL_W-1:0] sel);
        int unsigned sh;
        sh = 2 * int'(sel[1:0]) + 1 + int'(sel[2]);
        return CNT_W'((1 << sh) - 1);
    endfunction

    function automatic res_pair_t place_result(input logic [RES_W-1:0] r,
                                               input logic right);
        res_pair_t p;
        if (right) begin
            p.hi = {{PAD_W{1'b0}}, r[RES_W-1:BYTE_W]};
            p.lo = r[BYTE_W-1:0];
        end else begin
            p.hi = r[RES_W-1:RES_W-BYTE_W];
            p.lo = {r[RES_W-BYTE_W-1:0], {PAD_W{1'b0}}};
        end
        return p;
    endfunction
endpackage

// File: rtl/sar_clkgen.sv
`timescale 1ns/1ps
module sar_clkgen
    import sar_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic             hold,
    input  logic [SEL_W-1:0] sel,
    input  logic             rc_tick,
    output logic             step_en
);
    localparam int PIPE_W = SYNC_STAGES + 1;

    logic [PIPE_W-1:0] rc_pipe;
    logic              rc_rise;
    logic [CNT_W-1:0]  cnt_q;
    logic [CNT_W-1:0]  terminal;
    logic              rc_mode;
    logic              div_hit;

    always_ff @(posedge clk) begin
        if (rst) rc_pipe <= '0;
        else     rc_pipe <= {rc_pipe[PIPE_W-2:0], rc_tick};
    end

    assign rc_rise  = rc_pipe[SYNC_STAGES-1] & ~rc_pipe[SYNC_STAGES];
    assign terminal = div_terminal(sel);
    assign rc_mode  = is_rc_sel(sel);
    assign div_hit  = run && !rc_mode && !hold && (cnt_q == terminal);

    always_ff @(posedge clk) begin
        if (rst || !run)             cnt_q <= '0;
        else if (!rc_mode && !hold)  cnt_q <= div_hit ? '0 : cnt_q + 1'b1;
    end

    assign step_en = rc_mode ? (run & rc_rise) : div_hit;

    a_r12_hold_freezes_div: assert property (@(posedge clk) disable iff (rst)
        (run && hold && !rc_mode) |=> $stable(cnt_q));

    a_r3_div_steps_spaced: assert property (@(posedge clk) disable iff (rst)
        (step_en && !rc_mode) |=> (!step_en || rc_mode));
endmodule

// File: rtl/sar_stepper.sv
`timescale 1ns/1ps
module sar_stepper
    import sar_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic             abort,
    input  logic             step_en,
    input  logic             cmp_in,
    output logic             busy,
    output logic [RES_W-1:0] trial,
    output logic             done,
    output logic [RES_W-1:0] result
);
    sar_state_t       st_q, st_d;
    logic [RES_W-1:0] probe;
    logic             last;

    assign probe  = RES_W'(1) << st_q.idx;
    assign last   = (st_q.idx == '0);
    assign busy   = st_q.active;
    assign trial  = st_q.active ? (st_q.bits | probe) : '0;
    assign result = cmp_in ? (st_q.bits | probe) : st_q.bits;
    assign done   = st_q.active & step_en & last & ~abort;

    always_comb begin
        st_d = st_q;
        if (start) begin
            st_d.active = 1'b1;
            st_d.idx    = IDX_W'(RES_W - 1);
            st_d.bits   = '0;
        end else if (st_q.active && abort) begin
            st_d.active = 1'b0;
        end else if (st_q.active && step_en) begin
            st_d.bits = result;
            if (last) st_d.active = 1'b0;
            else      st_d.idx    = st_q.idx - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    a_r5_first_trial_msb: assert property (@(posedge clk) disable iff (rst)
        start |=> (trial == {1'b1, {(RES_W-1){1'b0}}}));

    a_r8_done_ends_busy: assert property (@(posedge clk) disable iff (rst)
        done |=> !busy);

    a_r9_idle_without_start: assert property (@(posedge clk) disable iff (rst)
        (!busy && !start) |=> !busy);

    a_r5_midway_keeps_going: assert property (@(posedge clk) disable iff (rst)
        (busy && step_en && !abort && !last) |=> busy);
endmodule

// File: rtl/sar_regfile.sv
`timescale 1ns/1ps
module sar_regfile
    import sar_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr,
    input  logic [1:0]        addr,
    input  logic [BYTE_W-1:0] wdata,
    output logic [BYTE_W-1:0] rdata,
    input  logic              busy,
    input  logic              done,
    input  logic [RES_W-1:0]  result,
    output logic              start,
    output logic              abort,
    output cfg_t              cfg,
    output logic              irq
);
    logic      en_q;
    logic      flag_q;
    cfg_t      cfg_q;
    res_pair_t res_q;
    logic      ctrl_wr;
    logic      cfg_wr;
    logic      unused_wbits;

    assign unused_wbits = ^wdata[FMT_BIT-1:SEL_W];
    assign ctrl_wr = wr && (addr == ADDR_CTRL);
    assign cfg_wr  = wr && (addr == ADDR_CFG);
    assign start   = ctrl_wr && wdata[GO_BIT] && wdata[EN_BIT] && en_q && !busy;
    assign abort   = ctrl_wr && busy && (!wdata[GO_BIT] || !wdata[EN_BIT]);

    always_ff @(posedge clk) begin
        if (rst) begin
            en_q   <= 1'b0;
            flag_q <= 1'b0;
            cfg_q  <= '0;
            res_q  <= '0;
        end else begin
            if (ctrl_wr) en_q <= wdata[EN_BIT];
            if (cfg_wr)  cfg_q <= '{fmt_right: wdata[FMT_BIT], clk_sel: wdata[SEL_W-1:0]};
            if (done) begin
                res_q  <= place_result(result, cfg_q.fmt_right);
                flag_q <= 1'b1;
            end else if (ctrl_wr && !wdata[FLAG_BIT]) begin
                flag_q <= 1'b0;
            end
        end
    end

    always_comb begin
        unique case (reg_addr_e'(addr))
            ADDR_CTRL: rdata = {{(BYTE_W-3){1'b0}}, flag_q, busy, en_q};
            ADDR_CFG:  rdata = {cfg_q.fmt_right, {(BYTE_W-1-SEL_W){1'b0}}, cfg_q.clk_sel};
            ADDR_RHI:  rdata = res_q.hi;
            default:   rdata = res_q.lo;
        endcase
    end

    assign cfg = cfg_q;
    assign irq = flag_q;

    a_r8_done_sets_flag: assert property (@(posedge clk) disable iff (rst)
        done |=> irq);

    a_r10_abort_keeps_result: assert property (@(posedge clk) disable iff (rst)
        abort |=> ($stable(res_q) && $stable(flag_q)));

    a_r11_flag_sticky: assert property (@(posedge clk) disable iff (rst)
        (irq && !ctrl_wr) |=> irq);

    a_r2_result_bytes_readonly: assert property (@(posedge clk) disable iff (rst)
        !done |=> $stable(res_q));
endmodule

// File: rtl/sar_adc_ctrl.sv
`timescale 1ns/1ps
module sar_adc_ctrl
    import sar_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_wr,
    input  logic [1:0]        reg_addr,
    input  logic [BYTE_W-1:0] reg_wdata,
    output logic [BYTE_W-1:0] reg_rdata,
    input  logic              cmp_in,
    input  logic              rc_tick,
    input  logic              sleep_req,
    output logic [RES_W-1:0]  dac_code,
    output logic              irq
);
    logic             busy;
    logic             done;
    logic             start;
    logic             abort;
    logic             step_en;
    logic [RES_W-1:0] result;
    cfg_t             cfg;

    sar_regfile u_regs (
        .clk    (clk),
        .rst    (rst),
        .wr     (reg_wr),
        .addr   (reg_addr),
        .wdata  (reg_wdata),
        .rdata  (reg_rdata),
        .busy   (busy),
        .done   (done),
        .result (result),
        .start  (start),
        .abort  (abort),
        .cfg    (cfg),
        .irq    (irq)
    );

    sar_clkgen #(.SYNC_STAGES(2)) u_clk (
        .clk     (clk),
        .rst     (rst),
        .run     (busy),
        .hold    (sleep_req),
        .sel     (cfg.clk_sel),
        .rc_tick (rc_tick),
        .step_en (step_en)
    );

    sar_stepper u_sar (
        .clk     (clk),
        .rst     (rst),
        .start   (start),
        .abort   (abort),
        .step_en (step_en),
        .cmp_in  (cmp_in),
        .busy    (busy),
        .trial   (dac_code),
        .done    (done),
        .result  (result)
    );
endmodule

// File: tb/sar_adc_ctrl_tb.sv
`timescale 1ns/1ps
module sar_adc_ctrl_tb_top;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       reg_wr = 1'b0;
    logic [1:0] reg_addr = 2'd0;
    logic [7:0] reg_wdata = 8'd0;
    logic [7:0] reg_rdata;
    logic       cmp_in;
    logic       rc_tick = 1'b0;
    logic       sleep_req = 1'b0;
    logic [9:0] dac_code;
    logic       irq;
    logic [9:0] vin = 10'd0;

    int checks = 0;
    int failures = 0;
    bit finished = 0;

    always #2 clk = ~clk;

    assign cmp_in = (vin >= dac_code);

    sar_adc_ctrl dut_i (
        .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .cmp_in(cmp_in),
        .rc_tick(rc_tick), .sleep_req(sleep_req), .dac_code(dac_code), .irq(irq)
    );

    // {sel[2:0], fmt, vin[9:0]}
    localparam logic [13:0] VECS [6] = '{
        {3'b000, 1'b0, 10'h2A5},
        {3'b100, 1'b1, 10'h3FF},
        {3'b001, 1'b0, 10'h000},
        {3'b101, 1'b1, 10'h155},
        {3'b010, 1'b0, 10'h200},
        {3'b110, 1'b1, 10'h1FF}
    };

    function automatic logic [7:0] exp_hi(input logic [9:0] v, input logic right);
        return right ? {6'd0, v[9:8]} : v[9:2];
    endfunction
    function automatic logic [7:0] exp_lo(input logic [9:0] v, input logic right);
        return right ? v[7:0] : {v[1:0], 6'd0};
    endfunction
    function automatic int ratio(input logic [2:0] s);
        return 1 << (2 * int'(s[1:0]) + 1 + int'(s[2]));
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic chk_reg(input string req, input logic [1:0] a, input logic [7:0] exp);
        reg_addr = a;
        #0.2;
        chk(req, {24'd0, reg_rdata}, {24'd0, exp});
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic tick();
        @(negedge clk); rc_tick = 1'b1;
        @(negedge clk); rc_tick = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            failures++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1: reset state
        chk_reg("R1 ctrl", 2'd0, 8'h00);
        chk_reg("R1 cfg", 2'd1, 8'h00);
        chk_reg("R1 hi", 2'd2, 8'h00);
        chk_reg("R1 lo", 2'd3, 8'h00);
        chk("R1 dac", {22'd0, dac_code}, 32'd0);
        chk("R1 irq", {31'd0, irq}, 32'd0);

        // Table walk: R3 timing, R5, R6/R7, R8
        for (int i = 0; i < 6; i++) begin
            logic [2:0] s;
            logic       f;
            int         n;
            s = VECS[i][13:11]; f = VECS[i][10]; vin = VECS[i][9:0];
            n = ratio(s);
            wr(2'd1, {f, 4'd0, s});
            wr(2'd0, 8'b001);
            wr(2'd0, 8'b011);
            chk("R5 first trial", {22'd0, dac_code}, 32'h200);
            repeat (10 * n - 1) @(negedge clk);
            chk_reg("R3 still busy", 2'd0, 8'b011);
            @(negedge clk);
            chk_reg("R8 done ctrl", 2'd0, 8'b101);
            chk("R8 irq", {31'd0, irq}, 32'd1);
            chk_reg(f ? "R7 hi" : "R6 hi", 2'd2, exp_hi(vin, f));
            chk_reg(f ? "R7 lo" : "R6 lo", 2'd3, exp_lo(vin, f));
        end

        // R11: completion wins over a clear on the same edge
        vin = 10'h123;
        wr(2'd1, 8'h00);
        wr(2'd0, 8'b111);
        repeat (19) @(negedge clk);
        reg_wr = 1'b1; reg_addr = 2'd0; reg_wdata = 8'b011;
        @(negedge clk);
        reg_wr = 1'b0;
        chk_reg("R11 race flag kept", 2'd0, 8'b101);
        chk_reg("R11 race hi", 2'd2, 8'h48);
        chk_reg("R11 race lo", 2'd3, 8'hC0);
        wr(2'd0, 8'b001);
        chk_reg("R11 clear", 2'd0, 8'b001);
        wr(2'd0, 8'b101);
        chk_reg("R11 write one no set", 2'd0, 8'b001);
        chk("R11 irq low", {31'd0, irq}, 32'd0);

        // R10: software abort via start=0, then via enable=0
        vin = 10'h3C0;
        wr(2'd1, 8'h06);
        wr(2'd0, 8'b011);
        repeat (100) @(negedge clk);
        wr(2'd0, 8'b001);
        chk_reg("R10 abort go", 2'd0, 8'b001);
        chk("R10 dac idle", {22'd0, dac_code}, 32'd0);
        repeat (700) @(negedge clk);
        chk_reg("R10 hi kept", 2'd2, 8'h48);
        chk_reg("R10 lo kept", 2'd3, 8'hC0);
        chk("R10 irq kept", {31'd0, irq}, 32'd0);
        wr(2'd0, 8'b011);
        repeat (50) @(negedge clk);
        wr(2'd0, 8'b000);
        chk_reg("R10 abort en", 2'd0, 8'b000);
        repeat (700) @(negedge clk);
        chk_reg("R10 hi kept2", 2'd2, 8'h48);
        chk("R10 irq kept2", {31'd0, irq}, 32'd0);

        // R9: start while disabled is ignored
        wr(2'd0, 8'b010);
        chk_reg("R9 go no en", 2'd0, 8'b000);
        wr(2'd0, 8'b011);
        chk_reg("R9 go with en same write", 2'd0, 8'b001);
        repeat (700) @(negedge clk);
        chk_reg("R9 no result", 2'd2, 8'h48);
        chk("R9 no flag", {31'd0, irq}, 32'd0);

        // R12: sleep halts the divided clock
        vin = 10'h2F0;
        wr(2'd1, 8'h80);
        wr(2'd0, 8'b011);
        sleep_req = 1'b1;
        repeat (200) @(negedge clk);
        chk_reg("R12 held busy", 2'd0, 8'b011);
        sleep_req = 1'b0;
        repeat (25) @(negedge clk);
        chk_reg("R12 resumed done", 2'd0, 8'b101);
        chk_reg("R12 hi", 2'd2, 8'h02);
        chk_reg("R12 lo", 2'd3, 8'hF0);

        // R4 + R12: RC ticks during sleep
        vin = 10'h1A7;
        sleep_req = 1'b1;
        wr(2'd1, 8'h03);
        wr(2'd0, 8'b011);
        for (int k = 0; k < 9; k++) tick();
        repeat (10) @(negedge clk);
        chk_reg("R4 nine ticks busy", 2'd0, 8'b011);
        tick();
        chk_reg("R4 tenth tick done", 2'd0, 8'b101);
        chk_reg("R4 hi", 2'd2, 8'h69);
        chk_reg("R4 lo", 2'd3, 8'hC0);
        sleep_req = 1'b0;
        wr(2'd1, 8'h07);
        wr(2'd0, 8'b011);
        repeat (300) @(negedge clk);
        chk_reg("R4 sel111 no divider", 2'd0, 8'b011);
        wr(2'd0, 8'b001);

        // R1: reset aborts a running conversion
        wr(2'd1, 8'h06);
        wr(2'd0, 8'b011);
        repeat (50) @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        chk_reg("R1 abort ctrl", 2'd0, 8'h00);
        chk_reg("R1 abort cfg", 2'd1, 8'h00);
        chk_reg("R1 abort hi", 2'd2, 8'h00);
        chk_reg("R1 abort lo", 2'd3, 8'h00);
        chk("R1 abort dac", {22'd0, dac_code}, 32'd0);
        repeat (700) @(negedge clk);
        chk_reg("R1 stays idle", 2'd0, 8'h00);
        chk("R1 irq", {31'd0, irq}, 32'd0);

        // R2: register map details
        wr(2'd1, 8'hFF);
        chk_reg("R2 cfg unused zero", 2'd1, 8'h87);
        wr(2'd2, 8'hAA);
        wr(2'd3, 8'h55);
        chk_reg("R2 hi readonly", 2'd2, 8'h00);
        chk_reg("R2 lo readonly", 2'd3, 8'h00);

        finished = 1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule